// File: doc/BRIEF.md
# Descriptor-Chained DMA Engine with Tail Append

This block is a single DMA channel that follows a linked list of descriptors kept in a small internal descriptor store. Each descriptor names a destination word address, a byte length, the index of the next descriptor and a command field. For every descriptor the engine moves the payload from a source stream into destination memory, one 8-byte word per beat. It then either follows the next index or halts, when the next index is the stop sentinel. The destination memory is modelled as a plain registered write port.

Software builds each buffer as a run of data descriptors closed by one extra descriptor. While that buffer is the last in the chain, the extra descriptor is a finisher: its next index is the stop sentinel and its interrupt-enable bit is set. Once a buffer is added behind it, software rewrites the finisher in place into a linker. A linker points at the first descriptor of the next buffer and has a zero command. The rewrite can race with the engine. If the engine has already taken the finisher, it stops anyway. A link-miss check input then restarts an idle engine at the first buffer that is still pending. The end interrupt of the stale finisher still fires, so software gets another chance to run the check.

Top module: `descChainDma`

## Requirements
- R1: While reset is held, and right after it, `busy`, `memWrEn`, `endIrq` and `linkRestart` are low and `nextAddr` equals the stop sentinel 16, the 5-bit value with only bit 4 set.
- R2: A `startEn` pulse seen while idle loads `nextAddr` with `{0,startIdx}` and raises `busy` one cycle later. A `startEn` seen while busy is ignored.
- R3: A descriptor with byte length L produces L>>3 write beats; the low three bits of L are ignored. Beat k writes the k-th consumed source word to word address target+k. A beat is taken only in a cycle where `srcReady` and `srcValid` are both high. `memWrEn`, `memWrAddr` and `memWrData` are registered and appear one cycle after the beat.
- R4: Command bit 0 is interrupt-enable. When a descriptor with this bit set has finished its beats, `endIrq` pulses for one cycle. A descriptor with a zero command raises no interrupt.
- R5: After any descriptor whose next index has bit 4 set, the engine halts and `busy` falls. Otherwise it fetches the descriptor named by bits 3:0 of the next index.
- R6: `nextAddr` shows the next index of the most recently loaded descriptor, or the start or restart index until the first descriptor is loaded.
- R7: If a finisher is rewritten into a linker before the engine fetches it, the chain continues into the appended buffer, and the rewritten descriptor raises no interrupt.
- R8: A host descriptor write has priority over a fetch. A fetch that would coincide with a host write waits one cycle and then returns the newly written contents.
- R9: `chkEn` with `chkPending` high while idle restarts the engine at `chkIdx` and pulses `linkRestart` for one cycle. It has no effect while busy or when `chkPending` is low. A finisher rewritten after the engine loaded it still stops the engine and still raises its interrupt.
- R10: A descriptor with a length below 8 writes nothing but is still chained and still raises its interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Write one descriptor into the store |
| hostWrIdx | input | 4 | Descriptor index to write |
| hostTgt | input | 16 | Destination word address field |
| hostLen | input | 12 | Byte length field |
| hostNext | input | 5 | Next index field (bit 4 set = stop) |
| hostCmd | input | 4 | Command field (bit 0 = interrupt enable) |
| startEn | input | 1 | Start the engine at startIdx |
| startIdx | input | 4 | First descriptor to fetch |
| chkEn | input | 1 | Link-miss check strobe |
| chkPending | input | 1 | Host still has queued buffers |
| chkIdx | input | 4 | First descriptor of the oldest pending buffer |
| srcValid | input | 1 | Source word available |
| srcData | input | 64 | Source word |
| srcReady | output | 1 | Engine can accept a source word |
| memWrEn | output | 1 | Destination write strobe |
| memWrAddr | output | 16 | Destination word address |
| memWrData | output | 64 | Destination data |
| busy | output | 1 | Engine is running |
| nextAddr | output | 5 | Latched next-descriptor index |
| endIrq | output | 1 | End-of-chain interrupt pulse |
| linkRestart | output | 1 | Pulse: link-miss check restarted the engine |

## Verification
A wrong fetch index or a stale next index shows on `nextAddr` one cycle after the descriptor load, and as a bad `memWrAddr` on the first beat of the next descriptor. A miscounted remaining length shows as an extra or missing `memWrEn` beat, or as `busy` falling a cycle off. A lost arbitration shows as the old target address on the write port. A link-miss restart that fires at the wrong time appears on `linkRestart` and `busy` in the cycle after the check. Every port is compared against a behavioural model on every clock, so each of these faults is reported in the cycle where it first reaches a port.

// File: rtl/dmaChainPkg.sv
package dmaChainPkg;
  parameter int DESC_AW    = 4;
  parameter int MEM_AW     = 16;
  parameter int LEN_W      = 12;
  parameter int CMD_W      = 4;
  parameter int DATA_W     = 64;
  parameter int BEAT_BYTES = 8;
  parameter int IRQ_BIT    = 0;

  localparam int NEXT_W  = DESC_AW + 1;
  localparam int BEAT_SH = $clog2(BEAT_BYTES);
  localparam int REM_W   = LEN_W - BEAT_SH;
  localparam logic [NEXT_W-1:0] NEXT_STOP = NEXT_W'(1) << DESC_AW;

  typedef struct packed {
    logic [MEM_AW-1:0] tgt;
    logic [LEN_W-1:0]  lenB;
    logic [NEXT_W-1:0] next;
    logic [CMD_W-1:0]  cmd;
  } desc_t;

  typedef struct packed {
    logic loadStart;
    logic loadChk;
    logic fetchEn;
    logic latchDesc;
    logic beat;
    logic finish;
  } ctlStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_LOAD, ST_XFER} engState_e;
endpackage

// File: rtl/dmaDescRam.sv
module dmaDescRam
  import dmaChainPkg::*;
(
  input  logic               clk,
  input  logic               wrEn,
  input  logic [DESC_AW-1:0] wrIdx,
  input  desc_t              wrData,
  input  logic               rdEn,
  input  logic [DESC_AW-1:0] rdIdx,
  output desc_t              rdData
);
  localparam int DEPTH = 1 << DESC_AW;

  desc_t store [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) store[wrIdx] <= wrData;
    if (rdEn) rdData <= store[rdIdx];
  end
endmodule

// File: rtl/dmaCtrl.sv
module dmaCtrl
  import dmaChainPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startEn,
  input  logic       chkEn,
  input  logic       chkPending,
  input  logic       hostWrEn,
  input  logic       srcValid,
  input  logic       remZero,
  input  logic       nextIsStop,
  output ctlStrobe_t stb,
  output logic       busy,
  output logic       srcReady
);
  engState_e state, nxtState;

  always_comb begin
    stb      = '0;
    nxtState = state;
    unique case (state)
      ST_IDLE: begin
        if (startEn) begin
          stb.loadStart = 1'b1;
          nxtState      = ST_FETCH;
        end else if (chkEn && chkPending) begin
          stb.loadChk = 1'b1;
          nxtState    = ST_FETCH;
        end
      end
      ST_FETCH: begin
        // host rewrite owns the store this cycle; fetch retries next cycle
        if (!hostWrEn) begin
          stb.fetchEn = 1'b1;
          nxtState    = ST_LOAD;
        end
      end
      ST_LOAD: begin
        stb.latchDesc = 1'b1;
        nxtState      = ST_XFER;
      end
      ST_XFER: begin
        if (remZero) begin
          stb.finish = 1'b1;
          nxtState   = nextIsStop ? ST_IDLE : ST_FETCH;
        end else if (srcValid) begin
          stb.beat = 1'b1;
        end
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxtState;
  end

  assign busy     = (state != ST_IDLE);
  assign srcReady = (state == ST_XFER) && !remZero;
endmodule

// File: rtl/dmaDatapath.sv
module dmaDatapath
  import dmaChainPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         stb,
  input  logic [DESC_AW-1:0] startIdx,
  input  logic [DESC_AW-1:0] chkIdx,
  input  desc_t              rdData,
  input  logic [DATA_W-1:0]  srcData,
  output logic [NEXT_W-1:0]  nextAddr,
  output logic [DESC_AW-1:0] rdIdx,
  output logic               remZero,
  output logic               nextIsStop,
  output logic               memWrEn,
  output logic [MEM_AW-1:0]  memWrAddr,
  output logic [DATA_W-1:0]  memWrData,
  output logic               endIrq,
  output logic               linkRestart
);
  logic [NEXT_W-1:0] nextReg;
  logic [REM_W-1:0]  remCnt;
  logic [MEM_AW-1:0] curAddr;
  logic [CMD_W-1:0]  cmdReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextReg     <= NEXT_STOP;
      remCnt      <= '0;
      curAddr     <= '0;
      cmdReg      <= '0;
      memWrEn     <= 1'b0;
      memWrAddr   <= '0;
      memWrData   <= '0;
      endIrq      <= 1'b0;
      linkRestart <= 1'b0;
    end else begin
      memWrEn     <= stb.beat;
      endIrq      <= stb.finish && cmdReg[IRQ_BIT];
      linkRestart <= stb.loadChk;

      if (stb.loadStart)      nextReg <= {1'b0, startIdx};
      else if (stb.loadChk)   nextReg <= {1'b0, chkIdx};
      else if (stb.latchDesc) nextReg <= rdData.next;

      if (stb.latchDesc) begin
        remCnt  <= rdData.lenB[LEN_W-1:BEAT_SH];
        curAddr <= rdData.tgt;
        cmdReg  <= rdData.cmd;
      end else if (stb.beat) begin
        remCnt    <= remCnt - 1'b1;
        curAddr   <= curAddr + 1'b1;
        memWrAddr <= curAddr;
        memWrData <= srcData;
      end
    end
  end

  assign nextAddr   = nextReg;
  assign rdIdx      = nextReg[DESC_AW-1:0];
  assign remZero    = (remCnt == '0);
  assign nextIsStop = nextReg[DESC_AW];
endmodule

// File: rtl/descChainDma.sv
module descChainDma
  import dmaChainPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWrEn,
  input  logic [DESC_AW-1:0] hostWrIdx,
  input  logic [MEM_AW-1:0]  hostTgt,
  input  logic [LEN_W-1:0]   hostLen,
  input  logic [NEXT_W-1:0]  hostNext,
  input  logic [CMD_W-1:0]   hostCmd,
  input  logic               startEn,
  input  logic [DESC_AW-1:0] startIdx,
  input  logic               chkEn,
  input  logic               chkPending,
  input  logic [DESC_AW-1:0] chkIdx,
  input  logic               srcValid,
  input  logic [DATA_W-1:0]  srcData,
  output logic               srcReady,
  output logic               memWrEn,
  output logic [MEM_AW-1:0]  memWrAddr,
  output logic [DATA_W-1:0]  memWrData,
  output logic               busy,
  output logic [NEXT_W-1:0]  nextAddr,
  output logic               endIrq,
  output logic               linkRestart
);
  ctlStrobe_t         stb;
  desc_t              hostDesc;
  desc_t              rdData;
  logic [DESC_AW-1:0] rdIdx;
  logic               remZero;
  logic               nextIsStop;

  assign hostDesc = '{tgt: hostTgt, lenB: hostLen, next: hostNext, cmd: hostCmd};

  dmaDescRam u_ram (
    .clk    (clk),
    .wrEn   (hostWrEn),
    .wrIdx  (hostWrIdx),
    .wrData (hostDesc),
    .rdEn   (stb.fetchEn),
    .rdIdx  (rdIdx),
    .rdData (rdData)
  );

  dmaCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startEn    (startEn),
    .chkEn      (chkEn),
    .chkPending (chkPending),
    .hostWrEn   (hostWrEn),
    .srcValid   (srcValid),
    .remZero    (remZero),
    .nextIsStop (nextIsStop),
    .stb        (stb),
    .busy       (busy),
    .srcReady   (srcReady)
  );

  dmaDatapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .startIdx    (startIdx),
    .chkIdx      (chkIdx),
    .rdData      (rdData),
    .srcData     (srcData),
    .nextAddr    (nextAddr),
    .rdIdx       (rdIdx),
    .remZero     (remZero),
    .nextIsStop  (nextIsStop),
    .memWrEn     (memWrEn),
    .memWrAddr   (memWrAddr),
    .memWrData   (memWrData),
    .endIrq      (endIrq),
    .linkRestart (linkRestart)
  );
endmodule

// File: rtl/dmaChainChecker.sv
module dmaChainChecker
  import dmaChainPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              startEn,
  input logic              chkEn,
  input logic              chkPending,
  input logic              busy,
  input logic [NEXT_W-1:0] nextAddr,
  input logic              memWrEn,
  input logic              srcReady,
  input logic              endIrq,
  input logic              linkRestart
);
  p_stop_before_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(nextAddr[DESC_AW]));

  p_write_while_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> $past(busy));

  p_ready_when_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    srcReady |-> busy);

  p_irq_single_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    endIrq |=> !endIrq);

  p_restart_from_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    linkRestart |-> (busy && !$past(busy)));

  p_busy_rise_cause_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startEn || (chkEn && chkPending)));
endmodule

bind descChainDma dmaChainChecker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .startEn     (startEn),
  .chkEn       (chkEn),
  .chkPending  (chkPending),
  .busy        (busy),
  .nextAddr    (nextAddr),
  .memWrEn     (memWrEn),
  .srcReady    (srcReady),
  .endIrq      (endIrq),
  .linkRestart (linkRestart)
);

// File: tb/tb_descChainDma.sv
module tb_descChainDma;
  import dmaChainPkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN;
  logic        hostWrEn;
  logic [3:0]  hostWrIdx;
  logic [15:0] hostTgt;
  logic [11:0] hostLen;
  logic [4:0]  hostNext;
  logic [3:0]  hostCmd;
  logic        startEn;
  logic [3:0]  startIdx;
  logic        chkEn;
  logic        chkPending;
  logic [3:0]  chkIdx;
  logic        srcValid;
  logic [63:0] srcData;
  logic        srcReady;
  logic        memWrEn;
  logic [15:0] memWrAddr;
  logic [63:0] memWrData;
  logic        busy;
  logic [4:0]  nextAddr;
  logic        endIrq;
  logic        linkRestart;

  descChainDma dut (.*);

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int cyc = 0;
  bit gapMode = 0;
  logic [31:0] srcCnt = 0;
  assign srcData = {32'hD00DF00D, srcCnt};

  // reference model state
  int mPh, mNxt, mRem, mAddr, mCmd;
  int sT, sL, sN, sC;
  int mTgt[16], mLen[16], mNx[16], mCm[16];
  bit eWr, eIrq, eRst;
  int eWrA;
  logic [63:0] eWrD;

  // observation counters
  int wrSeen, irqSeen, rstSeen, lastWrA;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin : refModel
    eWr = 0; eIrq = 0; eRst = 0;
    if (!rstN) begin
      mPh = 0; mNxt = 16; mRem = 0; mAddr = 0; mCmd = 0;
    end else begin
      case (mPh)
        0: if (startEn) begin mNxt = startIdx; mPh = 1; end
           else if (chkEn && chkPending) begin mNxt = chkIdx; mPh = 1; eRst = 1; end
        1: if (!hostWrEn) begin
             sT = mTgt[mNxt % 16]; sL = mLen[mNxt % 16];
             sN = mNx[mNxt % 16];  sC = mCm[mNxt % 16];
             mPh = 2;
           end
        2: begin mNxt = sN; mRem = sL / 8; mAddr = sT; mCmd = sC; mPh = 3; end
        default: begin
          if (mRem == 0) begin
            eIrq = (mCmd % 2) == 1;
            mPh = (mNxt >= 16) ? 0 : 1;
          end else if (srcValid) begin
            eWr = 1; eWrA = mAddr; eWrD = {32'hD00DF00D, srcCnt};
            mRem--; mAddr = (mAddr + 1) % 65536;
          end
        end
      endcase
      if (hostWrEn) begin
        mTgt[hostWrIdx] = hostTgt; mLen[hostWrIdx] = hostLen;
        mNx[hostWrIdx] = hostNext; mCm[hostWrIdx] = hostCmd;
      end
    end
  end

  always @(negedge clk) begin : compare
    cyc++;
    if (rstN) begin
      chk(busy === (mPh != 0), "R5 busy", busy, mPh != 0);
      chk(nextAddr === 5'(mNxt), "R6 nextAddr", nextAddr, mNxt);
      chk(memWrEn === eWr, "R3 memWrEn", memWrEn, eWr);
      chk(srcReady === (mPh == 3 && mRem != 0), "R3 srcReady", srcReady, mPh == 3 && mRem != 0);
      if (eWr) begin
        chk(memWrAddr === 16'(eWrA), "R3 memWrAddr", memWrAddr, eWrA);
        chk(memWrData === eWrD, "R3 memWrData", memWrData, eWrD);
      end
      chk(endIrq === eIrq, "R4 endIrq", endIrq, eIrq);
      chk(linkRestart === eRst, "R9 linkRestart", linkRestart, eRst);
      if (memWrEn) begin wrSeen++; lastWrA = int'(memWrAddr); srcCnt <= srcCnt + 1; end
      if (endIrq) irqSeen++;
      if (linkRestart) rstSeen++;
    end
    srcValid = gapMode ? (cyc % 3 != 0) : 1'b1;
  end

  task automatic clearStats();
    wrSeen = 0; irqSeen = 0; rstSeen = 0; lastWrA = -1;
  endtask

  task automatic wrDesc(int idx, int tgt, int len, int nx, int cmd);
    hostWrEn = 1; hostWrIdx = 4'(idx); hostTgt = 16'(tgt);
    hostLen = 12'(len); hostNext = 5'(nx); hostCmd = 4'(cmd);
    @(negedge clk);
    hostWrEn = 0;
  endtask

  task automatic startAt(int idx);
    startEn = 1; startIdx = 4'(idx);
    @(negedge clk);
    startEn = 0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 500 && busy; i++) @(negedge clk);
    @(negedge clk);
    #2;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=idle", cyc);
    finishRun();
  end

  initial begin : stimulus
    rstN = 0; hostWrEn = 0; hostWrIdx = 0; hostTgt = 0; hostLen = 0; hostNext = 0;
    hostCmd = 0; startEn = 0; startIdx = 0; chkEn = 0; chkPending = 0; chkIdx = 0;
    srcValid = 1;
    clearStats();
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    chk(busy === 1'b0, "R1 busy in reset", busy, 0);
    chk(nextAddr === 5'd16, "R1 nextAddr in reset", nextAddr, 16);
    chk(memWrEn === 1'b0 && endIrq === 1'b0 && linkRestart === 1'b0, "R1 strobes in reset",
        {memWrEn, endIrq, linkRestart}, 0);
    @(negedge clk);
    rstN = 1;

    // buffer A: two data descriptors and a finisher
    wrDesc(0, 'h100, 32, 1, 0);
    wrDesc(1, 'h200, 21, 2, 0);
    wrDesc(2, 0, 0, 16, 1);
    wrDesc(5, 'h700, 8, 16, 1);
    clearStats();
    startAt(0);
    waitIdle();
    chk(wrSeen == 6, "R3 beat count, length low bits ignored", wrSeen, 6);
    chk(lastWrA == 'h201, "R3 last address", lastWrA, 'h201);
    chk(irqSeen == 1, "R4 finisher interrupt", irqSeen, 1);
    chk(nextAddr === 5'd16 && !busy, "R5 halted on stop", nextAddr, 16);

    // R2: start while busy is ignored
    clearStats();
    startAt(0);
    @(negedge clk);
    startAt(5);
    waitIdle();
    chk(wrSeen == 6 && lastWrA == 'h201, "R2 start while busy ignored", lastWrA, 'h201);

    // R7: append buffer B by rewriting the finisher into a linker, gapped source
    gapMode = 1;
    wrDesc(3, 'h300, 16, 4, 0);
    wrDesc(4, 0, 0, 16, 1);
    clearStats();
    startAt(0);
    wrDesc(2, 0, 0, 3, 0);
    waitIdle();
    chk(wrSeen == 8, "R7 appended buffer transferred", wrSeen, 8);
    chk(lastWrA == 'h301, "R7 last address in appended buffer", lastWrA, 'h301);
    chk(irqSeen == 1, "R7 linker raises no interrupt", irqSeen, 1);
    gapMode = 0;

    // R9: append races with the engine latching the stop sentinel
    wrDesc(5, 'h400, 8, 6, 0);
    wrDesc(6, 0, 0, 16, 1);
    clearStats();
    startAt(3);
    for (int i = 0; i < 200 && !(busy && nextAddr == 5'd16); i++) @(negedge clk);
    wrDesc(4, 0, 0, 5, 0);
    @(negedge clk);
    #2;
    chk(!busy && wrSeen == 2, "R9 engine stays stopped after late rewrite", wrSeen, 2);
    chk(irqSeen == 1, "R9 stale finisher still interrupts", irqSeen, 1);
    chkEn = 1; chkPending = 0; chkIdx = 5;
    @(negedge clk);
    chkEn = 0;
    @(negedge clk);
    #2;
    chk(!busy && rstSeen == 0, "R9 check without pending has no effect", rstSeen, 0);
    chkEn = 1; chkPending = 1;
    repeat (2) @(negedge clk);
    chkEn = 0; chkPending = 0;
    waitIdle();
    chk(rstSeen == 1, "R9 single restart, check while busy ignored", rstSeen, 1);
    chk(wrSeen == 3 && lastWrA == 'h400, "R9 pending buffer transferred", lastWrA, 'h400);
    chk(irqSeen == 2, "R9 restarted chain interrupts", irqSeen, 2);

    // R8: host write in the fetch cycle wins, fetch sees the new contents
    wrDesc(7, 'h500, 8, 16, 1);
    clearStats();
    startAt(7);
    wrDesc(7, 'h600, 8, 16, 1);
    waitIdle();
    chk(wrSeen == 1 && lastWrA == 'h600, "R8 deferred fetch sees rewrite", lastWrA, 'h600);

    // R10: zero and sub-beat lengths
    wrDesc(8, 'h800, 0, 9, 1);
    wrDesc(9, 'h900, 7, 16, 1);
    clearStats();
    startAt(8);
    waitIdle();
    chk(wrSeen == 0, "R10 no beats for short lengths", wrSeen, 0);
    chk(irqSeen == 2, "R10 short descriptors still interrupt", irqSeen, 2);

    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule